// File: doc/BRIEF.md
# Retimer Power and Mode Controller

This block is the control state machine of a four-lane serial video retimer. It decides whether the device is powered down, waiting in standby, or active. It has three independent power-down sources: a low hot-plug level, a power-down bit set by the host, and a deasserted output-enable pin. While the block is active, it picks redriver or retimer operation from a rate-above-threshold flag. The rate measurement itself lies outside the block.

The host writes a small configuration space through a single-cycle register-write port. That space holds the power-down bit and two swap controls. Dropping the output-enable pin wipes that configuration, so the host must write it again afterwards.

The rate flag and the signal-present flag pass through stability filters before they reach the state machine. A short glitch on either flag therefore changes neither the mode nor the power state.

Top module: `rtm_pwr_ctrl`

States and transitions:
- States: `ST_PDOWN`, `ST_STANDBY` and `ST_ACTIVE`.
- Any state moves to `ST_PDOWN` when a power-down request appears.
- `ST_PDOWN` moves to `ST_STANDBY` once every power-down request is gone.
- `ST_STANDBY` moves to `ST_ACTIVE` when a signal is seen or detection is turned off.
- `ST_ACTIVE` moves to `ST_STANDBY` when the signal is lost while detection is on.

## Requirements
- R1: After reset the power state is power-down, the mode is redriver (`mode_retimer_o`=0), both swap controls are off, and `lane_src_o` is the identity mapping.
- R2: While `hpd_i` is low, `pwr_state_o` reads power-down from the next clock edge on.
- R3: Writing a 1 to bit 3 of register address 0x09 gives power-down one cycle after the write edge. Writing 0 to that bit releases it.
- R4: While `oe_i` is low, the block is in power-down from the next edge on. The configuration registers are cleared, and writes made while `oe_i` is low are ignored.
- R5: Leaving power-down always passes through standby for at least one cycle before the block becomes active.
- R6: With `sigdet_en_i` high, the block stays in or enters standby while the filtered signal flag is false. That flag is true only when every lane's `sig_present_i` bit is set. With `sigdet_en_i` low, the block goes active regardless of the signal flags.
- R7: A change on `rate_high_i` or on the combined signal flag takes effect only after the new value has held for `FILT_CYCLES` consecutive clock edges. Shorter pulses are discarded.
- R8: `mode_retimer_o` equals the filtered rate flag: 0 selects redriver and 1 selects retimer.
- R9: Bit 0 of register 0x0A enables lane swap, which is honoured only while the block is active. Output lane k then takes source lane k XOR 1. Lane 0 is data 0, lane 1 is data 1, lane 2 is data 2 and lane 3 is the clock lane.
- R10: Bit 1 of register 0x0A requests polarity swap. `pol_inv_o` is all ones only when the block is active and in retimer mode, and all zeros otherwise. Polarity swap may be combined with lane swap.
- R11: With `term_float_i` high, `term_sel_o` follows the filtered rate flag. With `term_float_i` low, it follows `term_strap_i`.
- R12: The power state code is 00 for active, 01 for standby and 10 for power-down. The code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpd_i | input | 1 | Hot-plug level; low requests power-down |
| oe_i | input | 1 | Output enable; low requests power-down and clears registers |
| sigdet_en_i | input | 1 | Enables signal-detect standby |
| sig_present_i | input | NUM_LANES | Per-lane signal-present flags |
| rate_high_i | input | 1 | Measured rate is above the redriver/retimer threshold |
| term_float_i | input | 1 | Termination-control pin is floating |
| term_strap_i | input | 1 | Strapped termination choice |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | REG_AW | Register write address |
| wr_data_i | input | REG_DW | Register write data |
| pwr_state_o | output | 2 | Power state code |
| mode_retimer_o | output | 1 | 1 selects retimer, 0 selects redriver |
| term_sel_o | output | 1 | Termination select |
| lane_swap_o | output | 1 | Lane swap in effect |
| pol_inv_o | output | NUM_LANES | Per-lane polarity inversion |
| lane_src_o | output | NUM_LANES*SELW | Source lane index for each output lane |

## Verification
The bench builds the block with four lanes and `FILT_CYCLES` set to 4. With that filter length, every stability window can be walked edge by edge: a value held one edge too few has no effect, and a value held exactly long enough switches the mode or state. The short filter also lets the bench sweep all eight combinations of the three power-down sources. It runs the full cross of lane swap, polarity swap and rate, and every termination pin combination against both rate values, each case reaching a settled active state within a few cycles.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'b00,
        ST_STANDBY = 2'b01,
        ST_PDOWN   = 2'b10
    } pwr_st_e;

    localparam int ADDR_PWR   = 'h09;
    localparam int BIT_PD     = 3;
    localparam int ADDR_SWAP  = 'h0A;
    localparam int BIT_LSWAP  = 0;
    localparam int BIT_PSWAP  = 1;
endpackage

// File: rtl/rtm_deglitch.sv
module rtm_deglitch #(
    parameter int STABLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int CW = $clog2(STABLE + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o   <= 1'b0;
            cnt_q <= '0;
        end else if (d_i == q_o) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(STABLE - 1)) begin
            q_o   <= d_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtm_cfg_regs.sv
module rtm_cfg_regs #(
    parameter int REG_AW = 8,
    parameter int REG_DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_i,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [REG_DW-1:0] wr_data_i,
    output logic              pd_req_o,
    output logic              lswap_o,
    output logic              pswap_o
);
    import rtm_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n || !oe_i) begin
            pd_req_o <= 1'b0;
            lswap_o  <= 1'b0;
            pswap_o  <= 1'b0;
        end else if (wr_en_i) begin
            if (wr_addr_i == REG_AW'(ADDR_PWR)) begin
                pd_req_o <= wr_data_i[BIT_PD];
            end
            if (wr_addr_i == REG_AW'(ADDR_SWAP)) begin
                lswap_o <= wr_data_i[BIT_LSWAP];
                pswap_o <= wr_data_i[BIT_PSWAP];
            end
        end
    end
endmodule

// File: rtl/rtm_lane_map.sv
module rtm_lane_map #(
    parameter int NUM_LANES = 4,
    parameter int SELW      = 2
) (
    input  logic                      swap_i,
    output logic [NUM_LANES*SELW-1:0] src_o
);
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        localparam int PARTNER = k ^ 1;
        assign src_o[k*SELW +: SELW] = swap_i ? SELW'(PARTNER) : SELW'(k);
    end
endmodule

// File: rtl/rtm_pwr_ctrl.sv
module rtm_pwr_ctrl #(
    parameter int NUM_LANES   = 4,
    parameter int FILT_CYCLES = 16,
    parameter int REG_AW      = 8,
    parameter int REG_DW      = 8,
    localparam int SELW       = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hpd_i,
    input  logic                      oe_i,
    input  logic                      sigdet_en_i,
    input  logic [NUM_LANES-1:0]      sig_present_i,
    input  logic                      rate_high_i,
    input  logic                      term_float_i,
    input  logic                      term_strap_i,
    input  logic                      wr_en_i,
    input  logic [REG_AW-1:0]         wr_addr_i,
    input  logic [REG_DW-1:0]         wr_data_i,
    output logic [1:0]                pwr_state_o,
    output logic                      mode_retimer_o,
    output logic                      term_sel_o,
    output logic                      lane_swap_o,
    output logic [NUM_LANES-1:0]      pol_inv_o,
    output logic [NUM_LANES*SELW-1:0] lane_src_o
);
    import rtm_pkg::*;

    logic    sig_q, rate_q;
    logic    reg_pd, reg_lswap, reg_pswap;
    logic    pd_any, sig_missing;
    pwr_st_e state_q, state_d;

    rtm_deglitch #(.STABLE(FILT_CYCLES)) u_sig_filt (
        .clk(clk), .rst_n(rst_n), .d_i(&sig_present_i), .q_o(sig_q)
    );

    rtm_deglitch #(.STABLE(FILT_CYCLES)) u_rate_filt (
        .clk(clk), .rst_n(rst_n), .d_i(rate_high_i), .q_o(rate_q)
    );

    rtm_cfg_regs #(.REG_AW(REG_AW), .REG_DW(REG_DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .oe_i(oe_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .pd_req_o(reg_pd), .lswap_o(reg_lswap), .pswap_o(reg_pswap)
    );

    assign pd_any      = !hpd_i || !oe_i || reg_pd;
    assign sig_missing = sigdet_en_i && !sig_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PDOWN: begin
                if (!pd_any)          state_d = ST_STANDBY;   // exit via standby
            end
            ST_STANDBY: begin
                if (pd_any)           state_d = ST_PDOWN;
                else if (!sig_missing) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (pd_any)           state_d = ST_PDOWN;
                else if (sig_missing) state_d = ST_STANDBY;
            end
            default:                  state_d = ST_PDOWN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PDOWN;
        else        state_q <= state_d;
    end

    logic lswap_eff;

    // Outputs
    always_comb begin
        pwr_state_o    = state_q;
        mode_retimer_o = rate_q;
        term_sel_o     = term_float_i ? rate_q : term_strap_i;
        lswap_eff      = 1'b0;
        pol_inv_o      = '0;
        unique case (state_q)
            ST_ACTIVE: begin
                lswap_eff = reg_lswap;
                pol_inv_o = (reg_pswap && rate_q) ? '1 : '0;
            end
            ST_STANDBY, ST_PDOWN: begin
                lswap_eff = 1'b0;
            end
            default: lswap_eff = 1'b0;
        endcase
        lane_swap_o = lswap_eff;
    end

    rtm_lane_map #(.NUM_LANES(NUM_LANES), .SELW(SELW)) u_map (
        .swap_i(lswap_eff), .src_o(lane_src_o)
    );
endmodule

// File: rtl/rtm_pwr_ctrl_chk.sv
module rtm_pwr_ctrl_chk #(
    parameter int NUM_LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hpd_i,
    input logic                 oe_i,
    input logic                 rate_high_i,
    input logic [1:0]           pwr_state_o,
    input logic                 mode_retimer_o,
    input logic                 lane_swap_o,
    input logic [NUM_LANES-1:0] pol_inv_o
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_hpd_pdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hpd_i |=> pwr_state_o == 2'b10);

    assert_oe_pdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_i |=> pwr_state_o == 2'b10);

    assert_exit_standby_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(pwr_state_o) == 2'b10 && pwr_state_o != 2'b10)
        |-> pwr_state_o == 2'b01);

    assert_mode_follows_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode_retimer_o != $past(mode_retimer_o))
        |-> $past(rate_high_i) == mode_retimer_o);

    assert_lswap_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lane_swap_o |-> pwr_state_o == 2'b00);

    assert_pol_retimer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_inv_o != '0) |-> (mode_retimer_o && pwr_state_o == 2'b00
                               && pol_inv_o == '1));

    assert_code_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state_o != 2'b11);
endmodule

bind rtm_pwr_ctrl rtm_pwr_ctrl_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .hpd_i(hpd_i), .oe_i(oe_i),
    .rate_high_i(rate_high_i), .pwr_state_o(pwr_state_o),
    .mode_retimer_o(mode_retimer_o), .lane_swap_o(lane_swap_o),
    .pol_inv_o(pol_inv_o)
);

// File: tb/sim_rtm_pwr_ctrl.sv
module sim_rtm_pwr_ctrl;
    localparam int NL   = 4;
    localparam int FILT = 4;
    localparam int SW   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hpd, oe, sden, rate, tfl, tst, wen;
    logic [NL-1:0] sigp;
    logic [7:0] waddr, wdata;
    logic [1:0] pst;
    logic mode, tsel, lsw;
    logic [NL-1:0] pinv;
    logic [NL*SW-1:0] lsrc;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rtm_pwr_ctrl #(.NUM_LANES(NL), .FILT_CYCLES(FILT)) u0 (
        .clk(clk), .rst_n(rst_n), .hpd_i(hpd), .oe_i(oe), .sigdet_en_i(sden),
        .sig_present_i(sigp), .rate_high_i(rate), .term_float_i(tfl),
        .term_strap_i(tst), .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdata),
        .pwr_state_o(pst), .mode_retimer_o(mode), .term_sel_o(tsel),
        .lane_swap_o(lsw), .pol_inv_o(pinv), .lane_src_o(lsrc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wen = 1'b1; waddr = a; wdata = d;
        step(1);
        wen = 1'b0;
    endtask

    task automatic chk_map(input bit sw, input string req);
        for (int k = 0; k < NL; k++) begin
            int e;
            e = sw ? (k ^ 1) : k;
            chk(int'(lsrc[k*SW +: SW]) == e, req, int'(lsrc[k*SW +: SW]), e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        hpd = 1; oe = 1; sden = 1; sigp = '1; rate = 0;
        tfl = 0; tst = 0; wen = 0; waddr = 0; wdata = 0;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state (checked before any state edge propagates a change)
        rst_n = 1'b0; step(1);
        chk(pst == 2'b10, "R1 state", pst, 2);
        chk(mode == 0, "R1 mode", mode, 0);
        chk(lsw == 0 && pinv == 0, "R1 swaps", {lsw, pinv}, 0);
        chk_map(0, "R1 map");
        rst_n = 1'b1;

        // R5 / R6 bring-up: PD -> STANDBY -> ACTIVE after filter
        step(1);
        chk(pst == 2'b01, "R5 standby first", pst, 1);
        step(FILT + 1);
        chk(pst == 2'b00, "R6 active with signal", pst, 0);

        // R2/R3/R4 sweep over power-down sources
        for (int c = 0; c < 8; c++) begin
            bit h, o, p, e;
            h = c[0]; o = c[1]; p = c[2];
            hpd = h; oe = o;
            wr(8'h09, p ? 8'h08 : 8'h00);
            step(2);
            e = !h || !o || (p && o);
            chk((pst == 2'b10) == e, "R2 R3 R4 sweep", pst, e ? 2 : 0);
            hpd = 1; oe = 1;
            wr(8'h09, 8'h00);
            step(3);
            chk(pst == 2'b00, "R5 recovery", pst, 0);
        end

        // R3 exact timing and standby on exit
        wr(8'h09, 8'h08);
        chk(pst == 2'b00, "R3 not yet", pst, 0);
        step(1);
        chk(pst == 2'b10, "R3 pdown", pst, 2);
        wr(8'h09, 8'h00);
        chk(pst == 2'b10, "R3 still pd", pst, 2);
        step(1);
        chk(pst == 2'b01, "R5 exit standby", pst, 1);
        step(1);
        chk(pst == 2'b00, "R5 then active", pst, 0);

        // R4 register clear and writes ignored while oe low
        wr(8'h0A, 8'h01);
        step(1);
        chk(lsw == 1, "R9 lswap on", lsw, 1);
        oe = 0;
        wr(8'h0A, 8'h03);
        step(1);
        chk(pst == 2'b10, "R4 pdown", pst, 2);
        chk(lsw == 0, "R9 gated in pd", lsw, 0);
        oe = 1;
        step(3);
        chk(pst == 2'b00, "R4 back active", pst, 0);
        chk(lsw == 0, "R4 regs cleared", lsw, 0);

        // R7 rate filter window
        rate = 1;
        step(FILT - 1);
        chk(mode == 0, "R7 held short", mode, 0);
        step(1);
        chk(mode == 1, "R7 switch", mode, 1);
        rate = 0; step(FILT - 1); rate = 1; step(FILT + 1);
        chk(mode == 1, "R7 glitch ignored", mode, 1);

        // R6 / R7 signal loss
        sigp[2] = 0;
        step(FILT);
        chk(pst == 2'b00, "R7 sig hold", pst, 0);
        step(1);
        chk(pst == 2'b01, "R6 standby on loss", pst, 1);
        sden = 0;
        step(1);
        chk(pst == 2'b00, "R6 detect off active", pst, 0);
        sden = 1;
        step(1);
        chk(pst == 2'b01, "R6 detect on standby", pst, 1);
        sigp = '1;
        step(FILT + 1);
        chk(pst == 2'b00, "R6 signal back", pst, 0);

        // R8 R9 R10 R11 cross sweep
        for (int c = 0; c < 8; c++) begin
            bit ls, ps, rt;
            ls = c[0]; ps = c[1]; rt = c[2];
            wr(8'h0A, {6'b0, ps, ls});
            rate = rt;
            step(FILT + 2);
            chk(mode == rt, "R8 mode", mode, rt);
            chk(lsw == ls, "R9 lswap", lsw, ls);
            chk_map(ls, "R9 map");
            chk(pinv == ((ps && rt) ? 4'hF : 4'h0), "R10 pol", pinv, (ps && rt) ? 15 : 0);
            for (int t = 0; t < 4; t++) begin
                bit ex;
                tfl = t[0]; tst = t[1];
                #1;
                ex = tfl ? rt : tst;
                chk(tsel == ex, "R11 term", tsel, ex);
            end
            chk(pst != 2'b11, "R12 code", pst, 0);
        end

        // R10 gated outside active
        hpd = 0; step(1);
        chk(pinv == 0 && lsw == 0, "R10 gated pd", pinv, 0);
        chk(pst == 2'b10, "R12 pd code", pst, 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule